// File: doc/BRIEF.md
# Voltage and Current Fault Flag Router

This block turns a stream of voltage RMS results and a raw overcurrent comparator bit into qualified fault flags. It drives two active-low output pins. Each RMS result arrives with a valid/ready handshake and is tested against a high limit and a low limit. A flag rises only after a programmed number of back-to-back violating results. The first result inside the limits clears that flag and its count.

The overcurrent path filters the comparator input. The comparator must stay high for a programmed number of clock cycles before the fault is raised. A sticky copy of the fault is kept until software clears it. Each output pin has a 2-bit selector, and the two pins decode their selectors differently. All limits, counts, the delay and the selectors are plain register inputs.

The result stream never applies back-pressure: `rms_ready` is held high. A result counts on any cycle where `rms_valid` is high. Cycles with `rms_valid` low leave all voltage state untouched.

Top module: `fault_flag_router`

## Requirements
- R1: While reset is asserted, and on the first clock afterwards, `ov_flag`, `uv_flag`, `oc_fault` and `oc_latched` are 0, and the pins show only their selected inputs (e.g. `zc_in` when `pin0_sel` = 0).
- R2: A result strictly greater than `ov_limit` counts as an overvoltage violation; a result equal to the limit does not. `ov_flag` is 1 from the cycle after the accepted result that completes `event_need` consecutive violations.
- R3: A result strictly less than `uv_limit` counts as an undervoltage violation; a result equal to the limit does not. `uv_flag` is 1 from the cycle after the accepted result that completes `event_need` consecutive violations.
- R4: An accepted result that does not violate a limit clears that limit's flag and its run count on the next cycle. Cycles without `rms_valid` change neither the flags nor the counts.
- R5: An `event_need` of 0 behaves the same as 1.
- R6: `oc_fault` is 1 in the cycle after `oc_cmp` has been sampled high on `oc_delay`+1 consecutive clock edges, and stays 1 while `oc_cmp` stays high. A delay of 0 gives a one-cycle registered response.
- R7: `oc_fault` is 0 in the cycle after `oc_cmp` is sampled low.
- R8: `oc_latched` becomes 1 in the cycle after `oc_fault` is 1. It returns to 0 only after a clock edge on which `oc_clear` is 1 and `oc_fault` is 0. A clear while `oc_fault` is 1 has no effect.
- R9: Pin 0 function by `pin0_sel`: 0 = `zc_in`, 1 = overvoltage, 2 = undervoltage, 3 = overvoltage OR undervoltage.
- R10: Pin 1 function by `pin1_sel`: 0 = `oc_fault`, 1 = undervoltage, 2 = overvoltage, 3 = overvoltage OR undervoltage OR `oc_latched`.
- R11: Both pins are low-true: `pinX_n` is the inverse of the selected function. It follows selector and `zc_in` changes in the same cycle.
- R12: `rms_ready` is 1 on every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rms_valid | input | 1 | RMS result valid |
| rms_ready | output | 1 | Always 1; no back-pressure |
| rms_value | input | W | Voltage RMS result |
| ov_limit | input | W | Overvoltage limit |
| uv_limit | input | W | Undervoltage limit |
| event_need | input | CW | Consecutive violations required (0 acts as 1) |
| zc_in | input | 1 | Zero-crossing indication |
| oc_cmp | input | 1 | Raw overcurrent comparator bit |
| oc_delay | input | DW | Overcurrent qualification delay in cycles |
| oc_clear | input | 1 | Clear request for the latched fault |
| pin0_sel | input | 2 | Pin 0 function select |
| pin1_sel | input | 2 | Pin 1 function select |
| pin0_n | output | 1 | Output pin 0, active low |
| pin1_n | output | 1 | Output pin 1, active low |
| ov_flag | output | 1 | Qualified overvoltage flag |
| uv_flag | output | 1 | Qualified undervoltage flag |
| oc_fault | output | 1 | Delay-qualified overcurrent fault |
| oc_latched | output | 1 | Sticky overcurrent fault |

## Verification
The hardest situations to reach are a run of violations broken only by idle cycles, and a latch-clear request that arrives while the fault is still active.

The stimulus builds a violation run that is interleaved with cycles where `rms_valid` is low. It also makes the comparator drop one cycle short of the delay and then hold high. While the fault is high, the stimulus pulses `oc_clear`, and pulses it again after the fault falls.

Both selectors and `zc_in` are stepped on every cycle from a free-running counter. As a result, every pin code is observed against whatever flag state the other stimulus has produced. A behavioural model checks each output on every cycle.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
  typedef enum logic [1:0] {
    P0_ZC   = 2'd0,
    P0_OV   = 2'd1,
    P0_UV   = 2'd2,
    P0_VANY = 2'd3
  } pin0_fn_e;

  typedef enum logic [1:0] {
    P1_OC   = 2'd0,
    P1_UV   = 2'd1,
    P1_OV   = 2'd2,
    P1_ALL  = 2'd3
  } pin1_fn_e;

  localparam int unsigned LIM_HIGH = 0;
  localparam int unsigned LIM_LOW  = 1;
  localparam int unsigned LIM_CNT  = 2;
endpackage

// File: rtl/rms_limit_qual.sv
module rms_limit_qual #(
  parameter int unsigned W       = 16,
  parameter int unsigned CW      = 4,
  parameter bit          IS_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [W-1:0]  value,
  input  logic [W-1:0]  limit,
  input  logic [CW-1:0] need,
  output logic          flag
);
  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

  logic [CW-1:0] run_q;
  logic          viol;
  logic [CW:0]   need_eff;
  logic [CW:0]   run_next;

  always_comb begin
    viol     = IS_HIGH ? (value > limit) : (value < limit);
    need_eff = (need == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, need};
    run_next = {1'b0, run_q} + {{CW{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      flag  <= 1'b0;
    end else if (take) begin
      if (viol) begin
        if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        if (run_next >= need_eff) flag <= 1'b1;
      end else begin
        run_q <= '0;
        flag  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/oc_fault_unit.sv
module oc_fault_unit #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp,
  input  logic [DW-1:0] delay,
  input  logic          clear,
  output logic          fault,
  output logic          latched
);
  localparam logic [DW-1:0] HOLD_MAX = {DW{1'b1}};

  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      fault  <= 1'b0;
    end else if (cmp) begin
      if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
      if (hold_q >= delay) fault <= 1'b1;
    end else begin
      hold_q <= '0;
      fault  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latched <= 1'b0;
    else if (fault)  latched <= 1'b1;
    else if (clear)  latched <= 1'b0;
  end
endmodule

// File: rtl/pin_select.sv
module pin_select
  import ffr_pkg::*;
(
  input  logic [1:0] sel0,
  input  logic [1:0] sel1,
  input  logic       zc,
  input  logic       ov,
  input  logic       uv,
  input  logic       oc,
  input  logic       oc_lat,
  output logic       pin0_n,
  output logic       pin1_n
);
  logic fn0, fn1;

  always_comb begin
    unique case (pin0_fn_e'(sel0))
      P0_ZC:   fn0 = zc;
      P0_OV:   fn0 = ov;
      P0_UV:   fn0 = uv;
      default: fn0 = ov | uv;
    endcase
    unique case (pin1_fn_e'(sel1))
      P1_OC:   fn1 = oc;
      P1_UV:   fn1 = uv;
      P1_OV:   fn1 = ov;
      default: fn1 = ov | uv | oc_lat;
    endcase
    pin0_n = ~fn0;
    pin1_n = ~fn1;
  end
endmodule

// File: rtl/fault_flag_router.sv
module fault_flag_router
  import ffr_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rms_valid,
  output logic          rms_ready,
  input  logic [W-1:0]  rms_value,
  input  logic [W-1:0]  ov_limit,
  input  logic [W-1:0]  uv_limit,
  input  logic [CW-1:0] event_need,
  input  logic          zc_in,
  input  logic          oc_cmp,
  input  logic [DW-1:0] oc_delay,
  input  logic          oc_clear,
  input  logic [1:0]    pin0_sel,
  input  logic [1:0]    pin1_sel,
  output logic          pin0_n,
  output logic          pin1_n,
  output logic          ov_flag,
  output logic          uv_flag,
  output logic          oc_fault,
  output logic          oc_latched
);
  logic [LIM_CNT-1:0]   lim_flag;
  logic [W-1:0]         lim_val [LIM_CNT];
  logic                 take;

  assign rms_ready = 1'b1;
  assign take      = rms_valid & rms_ready;
  assign lim_val[LIM_HIGH] = ov_limit;
  assign lim_val[LIM_LOW]  = uv_limit;

  for (genvar g = 0; g < LIM_CNT; g++) begin : g_lim
    rms_limit_qual #(
      .W(W), .CW(CW), .IS_HIGH(g == LIM_HIGH)
    ) u_qual (
      .clk(clk), .rst_n(rst_n), .take(take), .value(rms_value),
      .limit(lim_val[g]), .need(event_need), .flag(lim_flag[g])
    );
  end

  assign ov_flag = lim_flag[LIM_HIGH];
  assign uv_flag = lim_flag[LIM_LOW];

  oc_fault_unit #(.DW(DW)) u_oc (
    .clk(clk), .rst_n(rst_n), .cmp(oc_cmp), .delay(oc_delay),
    .clear(oc_clear), .fault(oc_fault), .latched(oc_latched)
  );

  pin_select u_pins (
    .sel0(pin0_sel), .sel1(pin1_sel), .zc(zc_in), .ov(ov_flag),
    .uv(uv_flag), .oc(oc_fault), .oc_lat(oc_latched),
    .pin0_n(pin0_n), .pin1_n(pin1_n)
  );
endmodule

// File: rtl/ffr_checker.sv
module ffr_checker #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rms_valid,
  input logic [W-1:0]  rms_value,
  input logic [W-1:0]  ov_limit,
  input logic [W-1:0]  uv_limit,
  input logic          oc_cmp,
  input logic          oc_clear,
  input logic [1:0]    pin0_sel,
  input logic [1:0]    pin1_sel,
  input logic          pin0_n,
  input logic          pin1_n,
  input logic          ov_flag,
  input logic          uv_flag,
  input logic          oc_fault,
  input logic          oc_latched
);
  // R2
  ov_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rms_valid && rms_value <= ov_limit) |=> !ov_flag);
  // R3
  uv_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rms_valid && rms_value >= uv_limit) |=> !uv_flag);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rms_valid |=> ($stable(ov_flag) && $stable(uv_flag)));
  // R6
  oc_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_fault) |-> $past(oc_cmp));
  // R7
  oc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_cmp |=> !oc_fault);
  // R8
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |=> oc_latched);
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latched && !oc_clear) |=> oc_latched);
  // R9
  pin0_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin0_sel == 2'd1) |-> (pin0_n == !ov_flag));
  // R10
  pin1_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin1_sel == 2'd0) |-> (pin1_n == !oc_fault));
endmodule

bind fault_flag_router ffr_checker #(.W(W), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rms_valid(rms_valid), .rms_value(rms_value),
  .ov_limit(ov_limit), .uv_limit(uv_limit), .oc_cmp(oc_cmp),
  .oc_clear(oc_clear), .pin0_sel(pin0_sel), .pin1_sel(pin1_sel),
  .pin0_n(pin0_n), .pin1_n(pin1_n), .ov_flag(ov_flag), .uv_flag(uv_flag),
  .oc_fault(oc_fault), .oc_latched(oc_latched)
);

// File: tb/tb_fault_flag_router.sv
module tb_fault_flag_router;
  localparam int PERIOD = 10;
  localparam int W = 16, CW = 4, DW = 8;

  logic clk = 0, rst_n = 0;
  logic rms_valid = 0, rms_ready;
  logic [W-1:0] rms_value = 0, ov_limit = 0, uv_limit = 0;
  logic [CW-1:0] event_need = 0;
  logic zc_in = 0, oc_cmp = 0, oc_clear = 0;
  logic [DW-1:0] oc_delay = 0;
  logic [1:0] pin0_sel = 0, pin1_sel = 0;
  logic pin0_n, pin1_n, ov_flag, uv_flag, oc_fault, oc_latched;

  int total = 0, bad = 0, cyc = 0;
  int m_ovrun = 0, m_uvrun = 0, m_ocrun = 0;
  bit m_ov = 0, m_uv = 0, m_oc = 0, m_lat = 0;
  bit done = 0;

  fault_flag_router #(.W(W), .CW(CW), .DW(DW)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s t=%0t actual=%0d expected=%0d", req, what, $time, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovrun = 0; m_uvrun = 0; m_ocrun = 0;
      m_ov = 0; m_uv = 0; m_oc = 0; m_lat = 0;
    end else begin
      int need;
      bit nlat, noc;
      need = (event_need == 0) ? 1 : int'(event_need);
      if (rms_valid) begin
        if (rms_value > ov_limit) begin
          m_ov = m_ov || (m_ovrun + 1 >= need);
          m_ovrun = (m_ovrun < 15) ? m_ovrun + 1 : 15;
        end else begin m_ovrun = 0; m_ov = 0; end
        if (rms_value < uv_limit) begin
          m_uv = m_uv || (m_uvrun + 1 >= need);
          m_uvrun = (m_uvrun < 15) ? m_uvrun + 1 : 15;
        end else begin m_uvrun = 0; m_uv = 0; end
      end
      nlat = m_oc ? 1'b1 : (oc_clear ? 1'b0 : m_lat);
      noc  = oc_cmp && (m_ocrun >= int'(oc_delay));
      m_ocrun = oc_cmp ? ((m_ocrun < 255) ? m_ocrun + 1 : 255) : 0;
      m_oc = noc; m_lat = nlat;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (!done) begin
    bit f0, f1;
    case (pin0_sel)
      2'd0: f0 = zc_in; 2'd1: f0 = m_ov; 2'd2: f0 = m_uv; default: f0 = m_ov | m_uv;
    endcase
    case (pin1_sel)
      2'd0: f1 = m_oc; 2'd1: f1 = m_uv; 2'd2: f1 = m_ov; default: f1 = m_ov | m_uv | m_lat;
    endcase
    chk("R2/R4/R5", "ov_flag", ov_flag, m_ov);
    chk("R3/R4/R5", "uv_flag", uv_flag, m_uv);
    chk("R6/R7", "oc_fault", oc_fault, m_oc);
    chk("R8", "oc_latched", oc_latched, m_lat);
    chk("R9/R11", "pin0_n", pin0_n, !f0);
    chk("R10/R11", "pin1_n", pin1_n, !f1);
    if (rst_n) chk("R12", "rms_ready", rms_ready, 1);
  end

  // selectors and zero crossing stepped on every cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    pin0_sel = cyc[1:0];
    pin1_sel = cyc[3:2] ^ cyc[1:0];
    zc_in    = cyc[2];
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(int v);
    rms_valid = 1; rms_value = W'(v); step(1); rms_valid = 0;
  endtask

  always @(posedge clk) if (!done && cyc > 20000) begin
    done = 1; bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ov_limit = 200; uv_limit = 100; event_need = 3; oc_delay = 4;
    step(4);
    // R1: reset state checked by the compare block while rst_n is low
    rst_n = 1; step(2);
    // R2: three violations required, equal value is not a violation
    send(250); send(250); send(200); send(250); send(250); send(250); step(2);
    send(150); step(2);                         // R4 clear
    send(250); step(1); send(250); step(3); send(250); step(2); // R4 idle gaps
    send(300); send(180); step(1);
    // R3 under, equal to the limit
    send(50); send(100); send(50); send(50); send(50); step(3);
    send(120); step(1);
    // R5 need 0 acts as 1
    event_need = 0; send(40); step(1); send(260); send(150); step(1);
    event_need = 1; send(201); send(99); step(2);
    event_need = 15; repeat (17) send(400); send(150);
    event_need = 2;
    // R6/R7 overcurrent: short pulse, then long hold
    oc_cmp = 1; step(4); oc_cmp = 0; step(2);
    oc_cmp = 1; step(8);
    oc_clear = 1; step(1); oc_clear = 0;        // R8 ignored while active
    step(4); oc_cmp = 0; step(3);
    oc_clear = 1; step(1); oc_clear = 0; step(3);
    oc_delay = 0; oc_cmp = 1; step(1); oc_cmp = 0; step(3);
    oc_clear = 1; step(1); oc_clear = 0;
    oc_delay = 255; oc_cmp = 1; step(300); oc_cmp = 0; step(2);
    // mixed activity with every selector code
    for (int i = 0; i < 40; i++) begin
      oc_cmp = (i % 7) > 1; oc_delay = DW'(i % 3);
      oc_clear = (i % 5) == 0;
      send((i % 3 == 0) ? 260 : ((i % 3 == 1) ? 60 : 150));
    end
    oc_clear = 0; oc_cmp = 0; step(4);
    rst_n = 0; step(2); rst_n = 1; step(2);     // R1 again mid-run
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule